// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Transmit Buffer

This block is a two-bank ping-pong packet buffer for the transmit side of a device-side IN endpoint. Firmware writes bytes one at a time into the bank that is currently open. It then commits that bank as a packet, and the block moves on to the other bank. The host-facing side starts reading when it receives a request pulse. It drains committed banks in the order they were committed, over a valid/ready/last byte stream. A committed bank that holds no bytes is reported through a separate one-cycle zero-length strobe.

The block keeps a count of busy (committed, not yet drained) banks, from 0 to 2. It shows a transmit-ready level whenever a bank is free for the CPU. It clears the write-allowed level once the open bank is full, and raises a sticky underflow flag when the host asks for data that is not there. A self-clearing kill command withdraws the most recently committed bank, as long as the host has not begun reading it. Firmware aborts all pending IN data by repeating kill until the busy count reads zero.

Top module: `ep_txbuf`

## Requirements
- R1: After reset the busy count is 0, tx_ready and rw_allowed are 1, and underflow, kill_busy, host_valid and host_zlp are 0.
- R2: A byte offered with cpu_wr_en while rw_allowed is 1 is stored at the next position of the open bank. rw_allowed drops once BANK_BYTES bytes are held. Bytes offered while rw_allowed is 0 are dropped and never appear at the host side.
- R3: A cpu_commit while fewer than 2 banks are busy raises the busy count by one, and the bank's length is the number of bytes written to it. tx_ready stays 1 after the commit when the other bank is free. With 2 banks busy, tx_ready and rw_allowed are 0 and a further commit is ignored.
- R4: On host_req with data pending, the oldest committed bank is sent starting on the cycle after the request. Each byte is shown with host_valid and accepted on host_ready. host_last marks the final byte, and the banks are drained in commit order.
- R5: A committed bank of length 0 is sent as a single-cycle host_zlp pulse with host_valid held at 0, and it frees its bank.
- R6: A host_req when no committed bank is available sets underflow, and the block produces neither host_valid nor host_zlp. underflow stays 1 until cpu_unf_clr is pulsed.
- R7: The busy count rises on each accepted commit and falls on each finished host read and on each executed kill. If a commit and a read completion land in the same cycle, the count does not change.
- R8: A cpu_kill sets kill_busy. On the next cycle it discards the most recently committed bank, lowers the busy count by one, moves the write side back to that bank and clears kill_busy. Data committed after the kill is sent after the older surviving packet.
- R9: A kill issued while the busy count is 0 changes nothing, and kill_busy returns to 0 one cycle after it was set.
- R10: A kill cannot discard a bank the host is already reading. While the only busy bank is being read, kill_busy stays 1. It clears one cycle after that read completes, and the read completes unharmed.
- R11: Repeating kill until the busy count is 0 leaves nothing queued, so the next host_req raises underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_en | input | 1 | Write one byte into the open bank |
| cpu_wr_data | input | DATA_W | Byte to write |
| cpu_commit | input | 1 | Commit the open bank as a packet (pulse) |
| cpu_kill | input | 1 | Request discard of the latest committed bank (pulse) |
| cpu_unf_clr | input | 1 | Clear the sticky underflow flag (pulse) |
| rw_allowed | output | 1 | Open bank exists and has room for a byte |
| tx_ready | output | 1 | A bank is free for the CPU |
| kill_busy | output | 1 | Kill request pending; self-clearing |
| busy_cnt | output | 2 | Number of committed, undrained banks |
| underflow | output | 1 | Sticky: host asked for data with none committed |
| host_req | input | 1 | Host starts reading a packet (pulse) |
| host_ready | input | 1 | Host accepts the byte on host_data |
| host_valid | output | 1 | host_data holds a packet byte |
| host_data | output | DATA_W | Packet byte |
| host_last | output | 1 | Current byte is the final byte of the packet |
| host_zlp | output | 1 | Current packet has zero length (one cycle) |

## Verification
A wrong busy count shows up within one cycle on tx_ready or rw_allowed. It shows up later as a missing or extra packet, or as an underflow that should not be there, on the next host request. A write pointer that fails to step back after a kill is first visible on the following packet pair: the host gets the packets in the wrong order or gets stale bytes. The sweep covers every packet length from empty to beyond one bank, checks each byte, the last marker and the zero-length strobe, and walks the kill and abort sequences through each busy level.

// File: rtl/ep_txbuf_pkg.sv
// Shared types for the dual-bank transmit buffer.
package ep_txbuf_pkg;

    // Host-side read state: waiting for a request, or streaming a bank.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_state_t;

    // Number of banks; the pointer logic relies on exactly two.
    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/ep_bank_store.sv
// Storage for the two packet banks and their committed lengths.
// Assumes: one write port and one asynchronous read port; at most one
// byte written and one length written per cycle.
module ep_bank_store #(
    parameter int unsigned BANK_BYTES = 8,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int unsigned LEN_W     = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              len_we,
    input  logic              len_bank,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [LEN_W-1:0]  rd_len
);
    import ep_txbuf_pkg::*;

    logic [DATA_W-1:0] mem   [NUM_BANKS][BANK_BYTES];
    logic [LEN_W-1:0]  len_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Byte storage of one bank: written only while it is the open bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == b[0])) begin
                mem[b][wr_idx] <= wr_data;
            end
        end

        // Committed length of one bank, captured at commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[b] <= '0;
            end else if (len_we && (len_bank == b[0])) begin
                len_q[b] <= len_val;
            end
        end
    end

    // Read port toward the host side.
    always_comb begin
        rd_data = mem[rd_bank][rd_idx];
        rd_len  = len_q[rd_bank];
    end

endmodule

// File: rtl/ep_bank_ctrl.sv
// CPU-side control: open-bank fill, commit, busy count and kill.
// Assumes: rd_done pulses for one cycle when the host finishes a bank;
// reading is high while the host streams the oldest busy bank.
module ep_bank_ctrl #(
    parameter int unsigned BANK_BYTES = 8,
    localparam int unsigned IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int unsigned LEN_W     = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_en,
    input  logic             cpu_commit,
    input  logic             cpu_kill,
    input  logic             reading,
    input  logic             rd_done,
    output logic             wr_acc,
    output logic             wr_ptr,
    output logic [IDX_W-1:0] wr_idx,
    output logic             len_we,
    output logic [LEN_W-1:0] len_val,
    output logic             kill_exec,
    output logic             kill_pend,
    output logic [1:0]       busy_cnt,
    output logic             rw_allowed,
    output logic             tx_ready
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(BANK_BYTES);

    logic [LEN_W-1:0] fill_q;
    logic             commit_ok;
    logic             kill_nop;
    logic [2:0]       busy_nx;

    // CPU-visible levels and accepted events for this cycle.
    always_comb begin
        tx_ready   = (busy_cnt != 2'd2);
        rw_allowed = tx_ready && (fill_q != FULL) && !kill_pend;
        wr_acc     = cpu_wr_en && rw_allowed;
        commit_ok  = cpu_commit && tx_ready && !kill_pend;
        kill_nop   = kill_pend && (busy_cnt == 2'd0);
        kill_exec  = kill_pend && (busy_cnt != 2'd0)
                     && !(reading && (busy_cnt == 2'd1));
        wr_idx     = IDX_W'(fill_q);
        len_we     = commit_ok;
        len_val    = fill_q + LEN_W'(wr_acc);
    end

    // Next busy count from commits, completed reads and executed kills.
    always_comb begin
        busy_nx = {1'b0, busy_cnt} + {2'b0, commit_ok}
                  - {2'b0, rd_done} - {2'b0, kill_exec};
    end

    // Busy-count register.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= 2'd0;
        else        busy_cnt <= busy_nx[1:0];
    end

    // Write pointer: steps forward on commit, back onto the killed bank on kill.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wr_ptr <= 1'b0;
        else if (commit_ok || kill_exec) wr_ptr <= ~wr_ptr;
    end

    // Fill level of the open bank; restarts when the bank changes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fill_q <= '0;
        else if (commit_ok || kill_exec) fill_q <= '0;
        else if (wr_acc)                 fill_q <= fill_q + 1'b1;
    end

    // Self-clearing kill request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     kill_pend <= 1'b0;
        else if (kill_exec || kill_nop) kill_pend <= 1'b0;
        else if (cpu_kill)              kill_pend <= 1'b1;
    end

endmodule

// File: rtl/ep_host_reader.sv
// Host-side reader: streams the oldest committed bank on request and
// flags underflow when nothing is available.
// Assumes: busy_cnt and kill_exec come from ep_bank_ctrl in the same cycle;
// a bank being executed by a kill is never started.
module ep_host_reader #(
    parameter int unsigned BANK_BYTES = 8,
    localparam int unsigned IDX_W     = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int unsigned LEN_W     = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_ready,
    input  logic [1:0]       busy_cnt,
    input  logic             kill_exec,
    input  logic [LEN_W-1:0] rd_len,
    input  logic             cpu_unf_clr,
    output logic             rd_ptr,
    output logic [IDX_W-1:0] rd_idx,
    output logic             reading,
    output logic             rd_done,
    output logic             host_valid,
    output logic             host_last,
    output logic             host_zlp,
    output logic             underflow
);
    import ep_txbuf_pkg::*;

    rd_state_t        state;
    logic [LEN_W-1:0] pos_q;
    logic             avail;
    logic             start;
    logic             beat;

    // Request handling and stream outputs for the current cycle.
    always_comb begin
        avail      = (busy_cnt == 2'd2) || ((busy_cnt == 2'd1) && !kill_exec);
        start      = host_req && (state == RD_IDLE) && avail;
        reading    = (state == RD_SEND);
        host_zlp   = reading && (rd_len == '0);
        host_valid = reading && (rd_len != '0);
        host_last  = host_valid && (pos_q == rd_len - 1'b1);
        beat       = host_valid && host_ready;
        rd_done    = host_zlp || (beat && host_last);
        rd_idx     = IDX_W'(pos_q);
    end

    // Read state machine.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= RD_IDLE;
        else if (start)   state <= RD_SEND;
        else if (rd_done) state <= RD_IDLE;
    end

    // Byte position within the bank being sent.
    always_ff @(posedge clk) begin
        if (!rst_n)                pos_q <= '0;
        else if (start || rd_done) pos_q <= '0;
        else if (beat)             pos_q <= pos_q + 1'b1;
    end

    // Read pointer: moves to the other bank after each finished packet.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_ptr <= 1'b0;
        else if (rd_done) rd_ptr <= ~rd_ptr;
    end

    // Sticky underflow; a new underflow wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          underflow <= 1'b0;
        else if (host_req && (state == RD_IDLE) && !avail)   underflow <= 1'b1;
        else if (cpu_unf_clr)                                underflow <= 1'b0;
    end

endmodule

// File: rtl/ep_txbuf.sv
// Dual-bank IN endpoint transmit buffer (top).
// Ties the bank store, the CPU-side control and the host-side reader.
// Assumes: single clock, synchronous active-low reset, pulse inputs held
// for one cycle.
module ep_txbuf #(
    parameter int unsigned BANK_BYTES = 8,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_commit,
    input  logic              cpu_kill,
    input  logic              cpu_unf_clr,
    output logic              rw_allowed,
    output logic              tx_ready,
    output logic              kill_busy,
    output logic [1:0]        busy_cnt,
    output logic              underflow,
    input  logic              host_req,
    input  logic              host_ready,
    output logic              host_valid,
    output logic [DATA_W-1:0] host_data,
    output logic              host_last,
    output logic              host_zlp
);
    localparam int unsigned IDX_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;
    localparam int unsigned LEN_W = $clog2(BANK_BYTES + 1);

    logic             wr_acc;
    logic             wr_ptr;
    logic [IDX_W-1:0] wr_idx;
    logic             len_we;
    logic [LEN_W-1:0] len_val;
    logic             kill_exec;
    logic             rd_ptr;
    logic [IDX_W-1:0] rd_idx;
    logic [LEN_W-1:0] rd_len;
    logic             reading;
    logic             rd_done;

    ep_bank_ctrl #(.BANK_BYTES(BANK_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr_en  (cpu_wr_en),
        .cpu_commit (cpu_commit),
        .cpu_kill   (cpu_kill),
        .reading    (reading),
        .rd_done    (rd_done),
        .wr_acc     (wr_acc),
        .wr_ptr     (wr_ptr),
        .wr_idx     (wr_idx),
        .len_we     (len_we),
        .len_val    (len_val),
        .kill_exec  (kill_exec),
        .kill_pend  (kill_busy),
        .busy_cnt   (busy_cnt),
        .rw_allowed (rw_allowed),
        .tx_ready   (tx_ready)
    );

    ep_bank_store #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_acc),
        .wr_bank  (wr_ptr),
        .wr_idx   (wr_idx),
        .wr_data  (cpu_wr_data),
        .len_we   (len_we),
        .len_bank (wr_ptr),
        .len_val  (len_val),
        .rd_bank  (rd_ptr),
        .rd_idx   (rd_idx),
        .rd_data  (host_data),
        .rd_len   (rd_len)
    );

    ep_host_reader #(.BANK_BYTES(BANK_BYTES)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_ready  (host_ready),
        .busy_cnt    (busy_cnt),
        .kill_exec   (kill_exec),
        .rd_len      (rd_len),
        .cpu_unf_clr (cpu_unf_clr),
        .rd_ptr      (rd_ptr),
        .rd_idx      (rd_idx),
        .reading     (reading),
        .rd_done     (rd_done),
        .host_valid  (host_valid),
        .host_last   (host_last),
        .host_zlp    (host_zlp),
        .underflow   (underflow)
    );

endmodule

// File: rtl/ep_txbuf_chk.sv
// Protocol checker for ep_txbuf, attached by bind below.
module ep_txbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] busy_cnt,
    input logic       rw_allowed,
    input logic       tx_ready,
    input logic       kill_busy,
    input logic       underflow,
    input logic       cpu_unf_clr,
    input logic       host_req,
    input logic       host_valid,
    input logic       host_zlp,
    input logic       reading
);
    // R7
    busy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt != 2'd3);

    // R3
    full_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt == 2'd2) |-> (!rw_allowed && !tx_ready));

    // R9
    idle_kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_busy && busy_cnt == 2'd0) |=> !kill_busy);

    // R6
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !cpu_unf_clr) |=> underflow);

    // R6
    empty_req_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !reading && busy_cnt == 2'd0) |=> underflow);

    // R5
    zlp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && host_zlp));

    // R4
    valid_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid || host_zlp) |-> (busy_cnt != 2'd0));

endmodule

bind ep_txbuf ep_txbuf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_cnt    (busy_cnt),
    .rw_allowed  (rw_allowed),
    .tx_ready    (tx_ready),
    .kill_busy   (kill_busy),
    .underflow   (underflow),
    .cpu_unf_clr (cpu_unf_clr),
    .host_req    (host_req),
    .host_valid  (host_valid),
    .host_zlp    (host_zlp),
    .reading     (reading)
);

// File: tb/ep_txbuf_tb.sv
`timescale 1ns/1ps
module ep_txbuf_tb;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = 8'h00;
    logic       cpu_commit = 1'b0;
    logic       cpu_kill = 1'b0;
    logic       cpu_unf_clr = 1'b0;
    logic       host_req = 1'b0;
    logic       host_ready = 1'b1;
    logic       rw_allowed, tx_ready, kill_busy, underflow;
    logic       host_valid, host_last, host_zlp;
    logic [1:0] busy_cnt;
    logic [7:0] host_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ep_txbuf #(.BANK_BYTES(N), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_commit(cpu_commit), .cpu_kill(cpu_kill), .cpu_unf_clr(cpu_unf_clr),
        .rw_allowed(rw_allowed), .tx_ready(tx_ready), .kill_busy(kill_busy),
        .busy_cnt(busy_cnt), .underflow(underflow),
        .host_req(host_req), .host_ready(host_ready),
        .host_valid(host_valid), .host_data(host_data),
        .host_last(host_last), .host_zlp(host_zlp)
    );

    task automatic chk(input string rq, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); cpu_wr_en = 1'b1; cpu_wr_data = d;
        @(negedge clk); cpu_wr_en = 1'b0;
    endtask

    task automatic pulse_commit();
        @(negedge clk); cpu_commit = 1'b1;
        @(negedge clk); cpu_commit = 1'b0;
    endtask

    task automatic pulse_kill();
        @(negedge clk); cpu_kill = 1'b1;
        @(negedge clk); cpu_kill = 1'b0;
    endtask

    task automatic put_pkt(input int len, input logic [7:0] base);
        for (int i = 0; i < len; i++) wr_byte(base + 8'(i));
        pulse_commit();
    endtask

    // Requests one packet and checks every byte, the last marker and the ZLP strobe.
    task automatic get_pkt(input int len, input logic [7:0] base, input string rq);
        @(negedge clk); host_req = 1'b1;
        @(negedge clk); host_req = 1'b0;
        if (len == 0) begin
            chk({rq, " zlp"}, int'(host_zlp), 1);
            chk({rq, " zlp no valid"}, int'(host_valid), 0);
            @(negedge clk);
        end else begin
            for (int i = 0; i < len; i++) begin
                chk({rq, " valid"}, int'(host_valid), 1);
                chk({rq, " data"}, int'(host_data), int'(base + 8'(i)));
                chk({rq, " last"}, int'(host_last), (i == len - 1) ? 1 : 0);
                @(negedge clk);
            end
        end
        chk({rq, " idle after"}, int'(host_valid | host_zlp), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int kills;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy_cnt), 0);
        chk("R1 tx_ready", int'(tx_ready), 1);
        chk("R1 rw_allowed", int'(rw_allowed), 1);
        chk("R1 flags", int'({underflow, kill_busy, host_valid, host_zlp}), 0);

        // R6 underflow on empty request, sticky, cleared by CPU
        @(negedge clk); host_req = 1'b1;
        @(negedge clk); host_req = 1'b0;
        chk("R6 no data out", int'(host_valid | host_zlp), 0);
        chk("R6 set", int'(underflow), 1);
        repeat (3) @(negedge clk);
        chk("R6 sticky", int'(underflow), 1);
        @(negedge clk); cpu_unf_clr = 1'b1;
        @(negedge clk); cpu_unf_clr = 1'b0;
        chk("R6 cleared", int'(underflow), 0);

        // R2 R4 R5 sweep of every length, overflowing writes dropped
        for (int len = 0; len <= N + 2; len++) begin
            for (int b = 0; b < 2; b++) begin
                logic [7:0] base;
                int kept;
                base = 8'(16 * len + 8 * b + 1);
                kept = (len > N) ? N : len;
                for (int i = 0; i < len; i++) wr_byte(base + 8'(i));
                chk("R2 rw_allowed after fill", int'(rw_allowed), (len >= N) ? 0 : 1);
                pulse_commit();
                chk("R3 busy after commit", int'(busy_cnt), 1);
                chk("R3 tx_ready other free", int'(tx_ready), 1);
                get_pkt(kept, base, (kept == 0) ? "R5" : "R4");
                chk("R7 busy after read", int'(busy_cnt), 0);
            end
        end

        // R3 R4 both banks busy, extra commit ignored, order kept
        put_pkt(3, 8'h40);
        put_pkt(2, 8'h80);
        chk("R3 busy two", int'(busy_cnt), 2);
        chk("R3 tx_ready low", int'(tx_ready), 0);
        chk("R3 rw_allowed low", int'(rw_allowed), 0);
        wr_byte(8'hEE);
        pulse_commit();
        chk("R3 extra commit ignored", int'(busy_cnt), 2);
        get_pkt(3, 8'h40, "R4 first bank");
        get_pkt(2, 8'h80, "R4 second bank");

        // R7 commit and read completion in the same cycle
        put_pkt(1, 8'h11);
        wr_byte(8'h21);
        wr_byte(8'h22);
        @(negedge clk); host_req = 1'b1;
        @(negedge clk); host_req = 1'b0;
        chk("R7 single byte last", int'(host_last), 1);
        cpu_commit = 1'b1;
        @(negedge clk); cpu_commit = 1'b0;
        chk("R7 busy unchanged", int'(busy_cnt), 1);
        get_pkt(2, 8'h21, "R7 follow-on");

        // R9 kill with nothing busy
        @(negedge clk); cpu_kill = 1'b1;
        @(negedge clk); cpu_kill = 1'b0;
        chk("R9 kill set", int'(kill_busy), 1);
        @(negedge clk);
        chk("R9 kill cleared", int'(kill_busy), 0);
        chk("R9 busy unchanged", int'(busy_cnt), 0);

        // R8 kill latest bank, write pointer moves back
        put_pkt(3, 8'h10);
        put_pkt(2, 8'h20);
        @(negedge clk); cpu_kill = 1'b1;
        @(negedge clk); cpu_kill = 1'b0;
        chk("R8 kill pending", int'(kill_busy), 1);
        @(negedge clk);
        chk("R8 kill done", int'(kill_busy), 0);
        chk("R8 busy down", int'(busy_cnt), 1);
        put_pkt(1, 8'h30);
        get_pkt(3, 8'h10, "R8 survivor");
        get_pkt(1, 8'h30, "R8 replacement");

        // R10 kill waits while the only busy bank is being read
        put_pkt(2, 8'h60);
        host_ready = 1'b0;
        @(negedge clk); host_req = 1'b1;
        @(negedge clk); host_req = 1'b0;
        pulse_kill();
        repeat (3) @(negedge clk);
        chk("R10 kill held", int'(kill_busy), 1);
        chk("R10 busy held", int'(busy_cnt), 1);
        chk("R10 data intact", int'(host_data), 8'h60);
        host_ready = 1'b1;
        @(negedge clk);
        chk("R10 second byte", int'(host_data), 8'h61);
        chk("R10 second last", int'(host_last), 1);
        @(negedge clk);
        chk("R10 busy after read", int'(busy_cnt), 0);
        chk("R10 kill still set", int'(kill_busy), 1);
        @(negedge clk);
        chk("R10 kill cleared", int'(kill_busy), 0);

        // R11 abort loop
        put_pkt(2, 8'hA0);
        put_pkt(3, 8'hB0);
        kills = 0;
        while (busy_cnt != 2'd0 && kills < 5) begin
            pulse_kill();
            while (kill_busy) @(negedge clk);
            kills++;
        end
        chk("R11 kill count", kills, 2);
        chk("R11 busy zero", int'(busy_cnt), 0);
        @(negedge clk); host_req = 1'b1;
        @(negedge clk); host_req = 1'b0;
        chk("R11 nothing sent", int'(host_valid | host_zlp), 0);
        chk("R11 underflow", int'(underflow), 1);
        @(negedge clk); cpu_unf_clr = 1'b1;
        @(negedge clk); cpu_unf_clr = 1'b0;
        put_pkt(2, 8'h55);
        get_pkt(2, 8'h55, "R11 after abort");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule